// File: doc/BRIEF.md
# Two-Phase Join Batch Sequencer

This block sequences one join engine that owns a single shared memory port. A run starts with a pulse on `start`, which latches three things: where the "new" tuples live and how many there are, where the "old" tuples live and how many there are, and where results should be written. The run then moves through batches. For each batch the sequencer reads up to `N` new tuples and places them into the slots of a compare array. It then reads every old tuple once and streams each one past that batch. Meanwhile it takes merged results from the array into a result FIFO and writes them to consecutive result addresses.

Reads and writes share the one port, so only one access is issued per cycle. Writes take the port when the FIFO holds more than half its depth, or when no read is wanted. A new batch only begins once the previous batch has fully settled: the array is idle, the FIFO is empty and every write has been acknowledged. When the last batch has settled, `done` rises and stays high until the next `start`. The compare array is external and is reached through the `arr_*` signals.

Top module: `join_seq`

## Requirements
- R1: While reset is held and after its release, `done`, `mem_req`, `arr_slot_en` and `results_written` are all zero.
- R2: New tuples are read in ascending address order, in batches of `min(N, remaining)`. Tuple k of a batch is presented on `arr_load_*` with slot index k and its memory data. While that batch streams, bits 0..k-1 of `arr_slot_en` are set and all higher bits are clear.
- R3: For every batch, each old tuple at `old_base + j`, for j = 0..old_count-1, is read once in ascending order and presented once on `arr_old_*`. The total number of old reads equals the number of batches times `old_count`.
- R4: Results accepted on `arr_res_*` are written in acceptance order to `res_base + 0, 1, 2, ...`. `results_written` equals the number of write acknowledgements. A write is never issued while the FIFO is empty.
- R5: Whenever the result FIFO holds more than `DEPTH/2` entries, the access issued that cycle is a write.
- R6: The first read of every batch after the first is issued only when three conditions all hold: no results are queued, no write is awaiting acknowledgement, and `arr_idle` is high.
- R7: After the last batch settles, `done` rises and remains high with no memory access until the next `start`. A run with `new_count` = 0 reaches `done` without any read.
- R8: `arr_res_ready` is high exactly when the result FIFO holds fewer than `DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted while idle or done |
| new_base | input | AW | Address of the first new tuple |
| new_count | input | CW | Number of new tuples |
| old_base | input | AW | Address of the first old tuple |
| old_count | input | CW | Number of old tuples |
| res_base | input | AW | Address of the first result slot |
| done | output | 1 | Run complete, held until next start |
| results_written | output | CW | Acknowledged result writes this run |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data returned (in order) |
| mem_rdata | input | DW | Returned read data |
| mem_wack | input | 1 | Write acknowledged (in order) |
| arr_load_valid | output | 1 | Load a new tuple into a slot |
| arr_load_slot | output | SW | Slot index for the load |
| arr_load_data | output | DW | New tuple data |
| arr_slot_en | output | N | Slots holding valid new tuples |
| arr_old_valid | output | 1 | Old tuple presented to the array |
| arr_old_data | output | DW | Old tuple data |
| arr_res_valid | input | 1 | Array offers a merged result |
| arr_res_data | input | DW | Merged result |
| arr_res_ready | output | 1 | Result FIFO can accept |
| arr_idle | input | 1 | Array holds no pending result |

## Verification
Read data reaches the array in the same cycle that `mem_rvalid` is high: `arr_load_valid` and `arr_old_valid` follow it combinationally. A result offered while `arr_res_ready` is high enters the FIFO at that clock edge, and can leave as a write from the following cycle. `results_written` counts up on the edge at which each `mem_wack` is seen. The bench changes its inputs on the falling edge and samples one nanosecond later, which is where all port values apply to the coming rising edge. It models the memory and the array from those samples and compares totals and result contents only once `done` has been seen high.

// File: rtl/join_seq_pkg.sv
package join_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_STREAM = 3'd2,
    PH_DRAIN  = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;
endpackage

// File: rtl/join_seq_fifo.sv
module join_seq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  output logic [DW-1:0]   head,
  output logic [CNTW-1:0] count,
  output logic            full,
  output logic            empty
);
  logic [DW-1:0]   slot_q [DEPTH];
  logic [PW-1:0]   wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic entry_en;
    assign entry_en = push && (wr_ptr_q == PW'(e));
    always_ff @(posedge clk) begin
      if (entry_en) slot_q[e] <= push_data;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/join_seq_port.sv
module join_seq_port #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [AW-1:0]   res_base,
  input  logic            rd_want,
  input  logic [AW-1:0]   rd_addr,
  input  logic [CNTW-1:0] res_cnt,
  input  logic            res_empty,
  input  logic [DW-1:0]   res_head,
  input  logic            mem_wack,
  output logic            rd_fire,
  output logic            wr_fire,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            wr_idle,
  output logic [CW-1:0]   results_written
);
  logic [AW-1:0] rbase_q;
  logic [CW-1:0] wr_idx_q, wr_idx_d;
  logic [CW-1:0] ack_q, ack_d;
  logic [CW-1:0] pend_q, pend_d;

  assign wr_fire = !res_empty && ((res_cnt > CNTW'(HALF)) || !rd_want);
  assign rd_fire = rd_want && !wr_fire;

  always_comb begin
    wr_idx_d = clear ? '0 : wr_idx_q + CW'(wr_fire);
    ack_d    = clear ? '0 : ack_q + CW'(mem_wack);
    pend_d   = pend_q + CW'(wr_fire) - CW'(mem_wack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbase_q <= '0;
    end else if (clear) begin
      rbase_q <= res_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      ack_q    <= '0;
      pend_q   <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      ack_q    <= ack_d;
      pend_q   <= pend_d;
    end
  end

  assign mem_req         = wr_fire || rd_fire;
  assign mem_we          = wr_fire;
  assign mem_addr        = wr_fire ? (rbase_q + AW'(wr_idx_q)) : rd_addr;
  assign mem_wdata       = res_head;
  assign wr_idle         = (pend_q == '0);
  assign results_written = ack_q;
endmodule

// File: rtl/join_seq_ctrl.sv
module join_seq_ctrl
  import join_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] new_base,
  input  logic [CW-1:0] new_count,
  input  logic [AW-1:0] old_base,
  input  logic [CW-1:0] old_count,
  input  logic          rd_fire,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          drain_ok,
  output logic          accept,
  output logic          rd_want,
  output logic [AW-1:0] rd_addr,
  output logic          arr_load_valid,
  output logic [SW-1:0] arr_load_slot,
  output logic [DW-1:0] arr_load_data,
  output logic [N-1:0]  arr_slot_en,
  output logic          arr_old_valid,
  output logic [DW-1:0] arr_old_data,
  output logic          done,
  output phase_t        phase
);
  phase_t        phase_q, phase_d;
  logic [AW-1:0] nb_q, ob_q;
  logic [CW-1:0] nc_q, oc_q;
  logic [CW-1:0] next_q, next_d;
  logic [CW-1:0] blen_q, blen_d;
  logic [CW-1:0] iss_q, iss_d;
  logic [CW-1:0] rcv_q, rcv_d;
  logic [N-1:0]  slot_q, slot_d;
  logic [N-1:0]  fill_mask;
  logic [CW-1:0] rcv_nx, nxt_idx, remain;

  assign accept = start && ((phase_q == PH_IDLE) || (phase_q == PH_DONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q <= '0;
      ob_q <= '0;
      nc_q <= '0;
      oc_q <= '0;
    end else if (accept) begin
      nb_q <= new_base;
      ob_q <= old_base;
      nc_q <= new_count;
      oc_q <= old_count;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) fill_mask[i] = (CW'(i) < blen_q);
  end

  assign rcv_nx  = rcv_q + CW'(mem_rvalid);
  assign nxt_idx = next_q + blen_q;
  assign remain  = nc_q - nxt_idx;

  always_comb begin
    phase_d = phase_q;
    next_d  = next_q;
    blen_d  = blen_q;
    iss_d   = iss_q;
    rcv_d   = rcv_q;
    slot_d  = slot_q;
    case (phase_q)
      PH_IDLE, PH_DONE: begin
        if (accept) begin
          phase_d = PH_DRAIN;
          next_d  = '0;
          blen_d  = '0;
          iss_d   = '0;
          rcv_d   = '0;
          slot_d  = '0;
        end
      end
      PH_LOAD: begin
        iss_d = iss_q + CW'(rd_fire);
        rcv_d = rcv_nx;
        if (rcv_nx == blen_q) begin
          phase_d = PH_STREAM;
          iss_d   = '0;
          rcv_d   = '0;
          slot_d  = fill_mask;
        end
      end
      PH_STREAM: begin
        iss_d = iss_q + CW'(rd_fire);
        rcv_d = rcv_nx;
        if (rcv_nx == oc_q) begin
          phase_d = PH_DRAIN;
          iss_d   = '0;
          rcv_d   = '0;
          slot_d  = '0;
        end
      end
      PH_DRAIN: begin
        if (drain_ok) begin
          next_d = nxt_idx;
          iss_d  = '0;
          rcv_d  = '0;
          if (nxt_idx >= nc_q) begin
            phase_d = PH_DONE;
          end else begin
            phase_d = PH_LOAD;
            blen_d  = (remain >= CW'(N)) ? CW'(N) : remain;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      next_q  <= '0;
      blen_q  <= '0;
      iss_q   <= '0;
      rcv_q   <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= phase_d;
      next_q  <= next_d;
      blen_q  <= blen_d;
      iss_q   <= iss_d;
      rcv_q   <= rcv_d;
      slot_q  <= slot_d;
    end
  end

  assign rd_want = ((phase_q == PH_LOAD) && (iss_q < blen_q)) ||
                   ((phase_q == PH_STREAM) && (iss_q < oc_q));
  assign rd_addr = (phase_q == PH_LOAD) ? (nb_q + AW'(next_q + iss_q))
                                        : (ob_q + AW'(iss_q));

  assign arr_load_valid = (phase_q == PH_LOAD) && mem_rvalid;
  assign arr_load_slot  = rcv_q[SW-1:0];
  assign arr_load_data  = mem_rdata;
  assign arr_old_valid  = (phase_q == PH_STREAM) && mem_rvalid;
  assign arr_old_data   = mem_rdata;
  assign arr_slot_en    = slot_q;
  assign done           = (phase_q == PH_DONE);
  assign phase          = phase_q;
endmodule

// File: rtl/join_seq.sv
module join_seq
  import join_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int N     = 4,
  parameter int DEPTH = 8,
  localparam int SW   = (N > 1) ? $clog2(N) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] new_base,
  input  logic [CW-1:0] new_count,
  input  logic [AW-1:0] old_base,
  input  logic [CW-1:0] old_count,
  input  logic [AW-1:0] res_base,
  output logic          done,
  output logic [CW-1:0] results_written,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_wack,
  output logic          arr_load_valid,
  output logic [SW-1:0] arr_load_slot,
  output logic [DW-1:0] arr_load_data,
  output logic [N-1:0]  arr_slot_en,
  output logic          arr_old_valid,
  output logic [DW-1:0] arr_old_data,
  input  logic          arr_res_valid,
  input  logic [DW-1:0] arr_res_data,
  output logic          arr_res_ready,
  input  logic          arr_idle
);
  phase_t          phase;
  logic            accept, rd_want, rd_fire, wr_fire, wr_idle, drain_ok;
  logic [AW-1:0]   rd_addr;
  logic [CNTW-1:0] res_cnt;
  logic            res_full, res_empty, res_push;
  logic [DW-1:0]   res_head;

  assign res_push      = arr_res_valid && !res_full;
  assign arr_res_ready = !res_full;
  assign drain_ok      = arr_idle && res_empty && wr_idle;

  join_seq_ctrl #(.AW(AW), .DW(DW), .CW(CW), .N(N)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .new_base       (new_base),
    .new_count      (new_count),
    .old_base       (old_base),
    .old_count      (old_count),
    .rd_fire        (rd_fire),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .drain_ok       (drain_ok),
    .accept         (accept),
    .rd_want        (rd_want),
    .rd_addr        (rd_addr),
    .arr_load_valid (arr_load_valid),
    .arr_load_slot  (arr_load_slot),
    .arr_load_data  (arr_load_data),
    .arr_slot_en    (arr_slot_en),
    .arr_old_valid  (arr_old_valid),
    .arr_old_data   (arr_old_data),
    .done           (done),
    .phase          (phase)
  );

  join_seq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (res_push),
    .push_data (arr_res_data),
    .pop       (wr_fire),
    .head      (res_head),
    .count     (res_cnt),
    .full      (res_full),
    .empty     (res_empty)
  );

  join_seq_port #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) u_port (
    .clk             (clk),
    .rst_n           (rst_n),
    .clear           (accept),
    .res_base        (res_base),
    .rd_want         (rd_want),
    .rd_addr         (rd_addr),
    .res_cnt         (res_cnt),
    .res_empty       (res_empty),
    .res_head        (res_head),
    .mem_wack        (mem_wack),
    .rd_fire         (rd_fire),
    .wr_fire         (wr_fire),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .wr_idle         (wr_idle),
    .results_written (results_written)
  );
endmodule

// File: rtl/join_seq_sva.sv
module join_seq_sva
  import join_seq_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            done,
  input logic            mem_req,
  input logic            mem_we,
  input logic [N-1:0]    arr_slot_en,
  input logic [CNTW-1:0] res_cnt,
  input logic            wr_idle,
  input logic            arr_idle,
  input phase_t          phase
);
  assert_store_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_cnt > CNTW'(HALF)) |-> (mem_req && mem_we));

  assert_write_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (res_cnt != '0));

  assert_batch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && $past(phase) == PH_DRAIN) |->
      ($past(res_cnt) == '0 && $past(wr_idle) && $past(arr_idle)));

  assert_slot_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((arr_slot_en & (arr_slot_en + N'(1))) == '0));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind join_seq join_seq_sva #(.N(N), .DEPTH(DEPTH)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .arr_slot_en (arr_slot_en),
  .res_cnt     (res_cnt),
  .wr_idle     (wr_idle),
  .arr_idle    (arr_idle),
  .phase       (phase)
);

// File: tb/test_join_seq.sv
`timescale 1ns/1ps
module test_join_seq;
  localparam int AW = 16, DW = 16, CW = 16, N = 4, DEPTH = 8, SW = 2, LAT = 2;
  localparam logic [15:0] NB = 16'h0100, OB = 16'h0400, RB = 16'h1000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start;
  logic [AW-1:0] new_base, old_base, res_base;
  logic [CW-1:0] new_count, old_count;
  logic          done;
  logic [CW-1:0] results_written;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid, mem_wack;
  logic [DW-1:0] mem_rdata;
  logic          arr_load_valid, arr_old_valid, arr_res_valid, arr_res_ready, arr_idle;
  logic [SW-1:0] arr_load_slot;
  logic [DW-1:0] arr_load_data, arr_old_data, arr_res_data;
  logic [N-1:0]  arr_slot_en;

  join_seq #(.AW(AW), .DW(DW), .CW(CW), .N(N), .DEPTH(DEPTH)) i_join_seq (.*);

  int n_chk = 0, n_fail = 0;
  int cur_nc = 0, cur_oc = 0;
  int occ = 0, pend = 0, wr_cnt = 0, new_rd = 0, old_rd = 0, loads = 0, olds = 0;
  int v_ready = 0, v_prio = 0, v_gate = 0, v_new = 0, v_old = 0, v_wr = 0, v_load = 0, v_slot = 0;
  logic [15:0] q [256];
  int q_rd = 0, q_wr = 0, q_cnt = 0;
  logic [15:0] res_mem [256];
  logic [15:0] exp_res [256];
  int exp_n = 0;
  logic        rp_v [LAT];
  logic [15:0] rp_d [LAT];
  logic        wp_v [LAT];
  logic        nx_rv = 1'b0, nx_wv = 1'b0;
  logic [15:0] nx_rd = '0;

  function automatic logic [15:0] memval(input int a);
    return 16'(a * 37 + 5);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] n, input logic [15:0] o);
    return n ^ 16'(o << 3);
  endfunction

  function automatic int blen(input int b);
    return ((cur_nc - b * N) >= N) ? N : (cur_nc - b * N);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // memory and compare-array models
  initial begin
    for (int k = 0; k < LAT; k++) begin rp_v[k] = 1'b0; rp_d[k] = '0; wp_v[k] = 1'b0; end
    mem_rvalid = 1'b0; mem_rdata = '0; mem_wack = 1'b0;
    arr_res_valid = 1'b0; arr_res_data = '0; arr_idle = 1'b1;
    forever begin
      @(negedge clk);
      for (int k = LAT - 1; k > 0; k--) begin
        rp_v[k] = rp_v[k-1]; rp_d[k] = rp_d[k-1]; wp_v[k] = wp_v[k-1];
      end
      rp_v[0] = nx_rv; rp_d[0] = nx_rd; wp_v[0] = nx_wv;
      nx_rv = 1'b0; nx_wv = 1'b0;
      mem_rvalid = rp_v[LAT-1]; mem_rdata = rp_d[LAT-1]; mem_wack = wp_v[LAT-1];
      arr_res_valid = (q_cnt > 0); arr_res_data = q[q_rd]; arr_idle = (q_cnt == 0);
      #1;
      if (rst_n) begin
        int push, popw;
        push = 0; popw = 0;
        if (arr_res_ready != (occ < DEPTH)) v_ready++;
        if (occ > DEPTH / 2 && !(mem_req && mem_we)) v_prio++;
        if (arr_res_valid && arr_res_ready) begin
          push = 1; q_rd = (q_rd + 1) % 256; q_cnt--;
        end
        if (mem_req && mem_we) begin
          int idx;
          idx = int'(mem_addr) - int'(RB);
          if (idx != wr_cnt || occ == 0) v_wr++;
          else res_mem[idx] = mem_wdata;
          wr_cnt++; popw = 1; nx_wv = 1'b1; pend++;
        end else if (mem_req) begin
          int a;
          a = int'(mem_addr);
          if (a >= int'(NB) && a < int'(NB) + cur_nc) begin
            if (a - int'(NB) != new_rd) v_new++;
            if (new_rd % N == 0 && new_rd > 0 && !(pend == 0 && occ == 0 && q_cnt == 0)) v_gate++;
            new_rd++;
          end else if (a >= int'(OB) && a < int'(OB) + cur_oc) begin
            if (a - int'(OB) != old_rd % cur_oc) v_old++;
            old_rd++;
          end else v_new++;
          nx_rv = 1'b1; nx_rd = memval(a);
        end
        if (mem_wack) pend--;
        if (arr_load_valid) begin
          if (int'(arr_load_slot) != loads % N || arr_load_data != memval(int'(NB) + loads)) v_load++;
          loads++;
        end
        if (arr_old_valid) begin
          int b, len;
          logic [15:0] nv, ov;
          b = (loads - 1) / N; len = blen(b);
          if (arr_slot_en != N'((1 << len) - 1)) v_slot++;
          ov = memval(int'(OB) + olds % cur_oc);
          if (arr_old_data != ov) v_old++;
          for (int s = 0; s < len; s++) begin
            nv = memval(int'(NB) + b * N + s);
            if (nv[0] == ov[0]) begin q[q_wr] = merge(nv, ov); q_wr = (q_wr + 1) % 256; q_cnt++; end
          end
          olds++;
        end
        occ = occ + push - popw;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic run_cfg(input int nc, input int oc);
    int t, nb;
    @(negedge clk);
    cur_nc = nc; cur_oc = oc;
    occ = 0; pend = 0; wr_cnt = 0; new_rd = 0; old_rd = 0; loads = 0; olds = 0;
    v_ready = 0; v_prio = 0; v_gate = 0; v_new = 0; v_old = 0; v_wr = 0; v_load = 0; v_slot = 0;
    nb = (nc + N - 1) / N;
    exp_n = 0;
    for (int b = 0; b < nb; b++)
      for (int o = 0; o < oc; o++)
        for (int s = 0; s < blen(b); s++) begin
          logic [15:0] nv, ov;
          nv = memval(int'(NB) + b * N + s); ov = memval(int'(OB) + o);
          if (nv[0] == ov[0]) begin exp_res[exp_n] = merge(nv, ov); exp_n++; end
        end
    new_count = CW'(nc); old_count = CW'(oc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    #2;
    while (!done && t < 5000) begin @(negedge clk); #2; t++; end
    chk("R7", $sformatf("done nc=%0d oc=%0d", nc, oc), done, 1);
    chk("R4", "results_written", results_written, exp_n);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < exp_n; k++) if (res_mem[k] !== exp_res[k]) bad++;
      chk("R4", "result contents mismatches", bad, 0);
    end
    chk("R4", "write order/empty violations", v_wr, 0);
    chk("R2", "new reads", new_rd, nc);
    chk("R2", "new order violations", v_new, 0);
    chk("R2", "load slot/data violations", v_load, 0);
    chk("R2", "slot enable violations", v_slot, 0);
    chk("R3", "old reads", old_rd, nb * oc);
    chk("R3", "old order/data violations", v_old, 0);
    chk("R3", "old presentations", olds, nb * oc);
    chk("R5", "store priority violations", v_prio, 0);
    chk("R6", "batch gate violations", v_gate, 0);
    chk("R8", "ready violations", v_ready, 0);
    repeat (3) @(negedge clk);
    #2;
    chk("R7", "done held", done, 1);
    chk("R7", "quiet when done", mem_req, 0);
  endtask

  initial begin
    int nc_set [6];
    int oc_set [4];
    nc_set = '{0, 1, 3, 4, 5, 9};
    oc_set = '{0, 1, 2, 7};
    rst_n = 1'b0; start = 1'b0;
    new_base = NB; old_base = OB; res_base = RB; new_count = '0; old_count = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "done in reset", done, 0);
    chk("R1", "mem_req in reset", mem_req, 0);
    chk("R1", "slot enables in reset", arr_slot_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk("R1", "done after reset", done, 0);
    chk("R1", "results_written after reset", results_written, 0);
    chk("R1", "mem_req after reset", mem_req, 0);
    foreach (nc_set[i]) foreach (oc_set[j]) run_cfg(nc_set[i], oc_set[j]);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule